// File: doc/BRIEF.md
# Four-Channel Digital Port with Level Interrupts

The block is a small general-purpose digital port. It samples a set of input pins through a synchronizer and drives a set of output pins from a register. Each channel can raise an interrupt when its synchronized input sits at a chosen level. Software picks that level per channel, high or low, through a polarity register, and it gates each channel through an enable register.

Interrupt events collect in a sticky pending register. Software clears a pending bit by writing 1 to it. If the chosen level is still present after the clear, the bit sets again on the following clock. A single interrupt request line is the OR of all pending bits.

Software reaches every register through a synchronous register port with a word index, a write flag and byte enables. Read data appears one clock after the read request.

Top module: `gpio_lvl_irq_port`

## Requirements
- R1: Reading word index 0 returns the input pins after the synchronizer, with channel n in data bit n.
- R2: The output register at word index 1 resets to 0, drives the output pins with channel n from bit n, and reads back the last value written.
- R3: The interrupt enable register at word index 2 holds channels 0 to 3 in bits 0 to 3 and resets to 0. Bits 4 to 31 of every register read as 0.
- R4: In the polarity register at word index 3, a bit of 0 makes the channel's condition a low input and a bit of 1 makes it a high input.
- R5: The pending register at word index 4 is sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: A channel whose enable bit is 0 never sets its pending bit.
- R7: A clear takes effect at the write edge. If the enabled condition still holds, the pending bit sets again on the next clock edge.
- R8: The interrupt request output is high exactly when at least one pending bit is set.
- R9: A write changes a byte only when that byte's enable is 1. Channels 0 to 3 sit in byte lane 0, so a write with byte enable bit 0 clear changes no register.
- R10: Word indexes 5 to 7 read as 0 and a write to them changes no register. Read data appears on the clock edge after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 3 | Word index of the register |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after the request |
| pin_in | input | 4 | Asynchronous input pins |
| pin_out | output | 4 | Output pins |
| irq | output | 1 | Interrupt request, OR of the pending bits |

## Verification
The assertions assume that the pins settle well between changes and that register strobes are held for a single clock. The bench therefore changes a pin pattern only on a falling edge. It then waits several cycles before any pending check, so the synchronizer and the pending logic see one stable level and no transient pattern. The assertions on the pending logic also rely on reset being applied before any access. The bench issues every access as a one-cycle strobe from a falling edge, and it leaves the polarity and enable values stable while it measures the re-set timing of a cleared bit.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   localparam int unsigned IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      IDX_LEVEL = 3'd0,
      IDX_DRIVE = 3'd1,
      IDX_ARM   = 3'd2,
      IDX_SENSE = 3'd3,
      IDX_FLAG  = 3'd4
   } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] async_in,
   output logic [NUM_CH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lvl,
   input  logic [NUM_CH-1:0] arm,
   input  logic [NUM_CH-1:0] sense,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] flag_q,
   output logic              irq
);
   logic [NUM_CH-1:0] hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign hit[c] = arm[c] & ~(lvl[c] ^ sense[c]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flag_q[c] <= 1'b0;
         else if (clr[c]) flag_q[c] <= 1'b0;
         else if (hit[c]) flag_q[c] <= 1'b1;
      end

      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
         flag_q[c] && !clr[c] |=> flag_q[c]);
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
         clr[c] |=> !flag_q[c]);
      p_disarmed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !flag_q[c] && !arm[c] |=> !flag_q[c]);
      p_reassert_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !clr[c] && arm[c] && (lvl[c] == sense[c]) |=> flag_q[c]);
   end

   assign irq = |flag_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_en,
   input  logic                reg_wr,
   input  logic [IDX_W-1:0]    reg_addr,
   input  logic [DATA_W/8-1:0] reg_be,
   input  logic [DATA_W-1:0]   reg_wdata,
   input  logic [NUM_CH-1:0]   lvl,
   input  logic [NUM_CH-1:0]   flag,
   output logic [NUM_CH-1:0]   drive_q,
   output logic [NUM_CH-1:0]   arm_q,
   output logic [NUM_CH-1:0]   sense_q,
   output logic [NUM_CH-1:0]   clr,
   output logic [DATA_W-1:0]   reg_rdata
);
   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("gpio_regfile: DATA_W must be a multiple of 8");
   end
   if (NUM_CH > DATA_W) begin : g_bad_ch
      $error("gpio_regfile: NUM_CH must not exceed DATA_W");
   end

   logic [NUM_CH-1:0] wmask;
   logic [NUM_CH-1:0] wbits;
   logic              wr_stb;
   logic              rd_stb;
   logic [NUM_CH-1:0] rd_bits;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_ok;

   for (genvar b = 0; b < NUM_CH; b++) begin : g_mask
      assign wmask[b] = reg_be[b/8];
   end

   assign wr_stb = reg_en & reg_wr;
   assign rd_stb = reg_en & ~reg_wr;
   assign wbits  = reg_wdata[NUM_CH-1:0];
   assign unused_ok = ^{reg_wdata, reg_be, LANES[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= '0;
         arm_q   <= '0;
         sense_q <= '0;
      end else if (wr_stb) begin
         unique case (reg_addr)
            IDX_DRIVE: drive_q <= (drive_q & ~wmask) | (wbits & wmask);
            IDX_ARM:   arm_q   <= (arm_q   & ~wmask) | (wbits & wmask);
            IDX_SENSE: sense_q <= (sense_q & ~wmask) | (wbits & wmask);
            default:   ;
         endcase
      end
   end

   assign clr = (wr_stb && reg_addr == IDX_FLAG) ? (wbits & wmask) : '0;

   always_comb begin
      unique case (reg_addr)
         IDX_LEVEL: rd_bits = lvl;
         IDX_DRIVE: rd_bits = drive_q;
         IDX_ARM:   rd_bits = arm_q;
         IDX_SENSE: rd_bits = sense_q;
         IDX_FLAG:  rd_bits = flag;
         default:   rd_bits = '0;
      endcase
      rd_word = '0;
      rd_word[NUM_CH-1:0] = rd_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= rd_word;
   end

   assign reg_rdata = rdata_q;

   p_drive_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && reg_addr == IDX_DRIVE && (&wmask) |=> drive_q == $past(wbits));
   p_lane_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && (wmask == '0) |=> $stable(drive_q) && $stable(arm_q) && $stable(sense_q));
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(reg_rdata));
endmodule

// File: rtl/gpio_lvl_irq_port.sv
module gpio_lvl_irq_port
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_en,
   input  logic                reg_wr,
   input  logic [IDX_W-1:0]    reg_addr,
   input  logic [DATA_W/8-1:0] reg_be,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_CH-1:0]   pin_in,
   output logic [NUM_CH-1:0]   pin_out,
   output logic                irq
);
   logic [NUM_CH-1:0] lvl;
   logic [NUM_CH-1:0] arm;
   logic [NUM_CH-1:0] sense;
   logic [NUM_CH-1:0] clr;
   logic [NUM_CH-1:0] flag;

   gpio_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl)
   );

   gpio_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
      .lvl(lvl), .flag(flag), .drive_q(pin_out), .arm_q(arm),
      .sense_q(sense), .clr(clr), .reg_rdata(reg_rdata)
   );

   gpio_irq_core #(.NUM_CH(NUM_CH)) u_core (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .arm(arm), .sense(sense),
      .clr(clr), .flag_q(flag), .irq(irq)
   );

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(arm != '0));
   p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq && ($past(clr) == '0) && !$past(irq) |-> $past(arm != '0));
endmodule

// File: tb/gpio_lvl_irq_port_bench.sv
module gpio_lvl_irq_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_en = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  pin_in = '0;
   logic [3:0]  pin_out;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_lvl_irq_port u_gpio_lvl_irq_port (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_en = 1'b0; reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
      @(negedge clk);
      reg_en = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check($sformatf("R3 reset word %0d", a), d, 32'h0);
      end
      check("R2 reset pins", {28'h0, pin_out}, 32'h0);
      check("R8 reset irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_input;
      logic [31:0] d;
      @(negedge clk); pin_in = 4'b1010;
      idle(3);
      rd(3'd0, d); check("R1 input 1010", d, 32'hA);
      @(negedge clk); pin_in = 4'b0101;
      idle(3);
      rd(3'd0, d); check("R1 input 0101", d, 32'h5);
   endtask

   task automatic t_output;
      logic [31:0] d;
      wr(3'd1, 32'hFFFF_FFF5, 4'hF);
      check("R2 pins drive", {28'h0, pin_out}, 32'h5);
      rd(3'd1, d); check("R2/R3 readback upper zero", d, 32'h5);
      wr(3'd1, 32'h0000_000A, 4'b1110);
      rd(3'd1, d); check("R9 lane0 off keeps drive", d, 32'h5);
      wr(3'd1, 32'h0000_000A, 4'b0001);
      check("R9 lane0 on updates pins", {28'h0, pin_out}, 32'hA);
   endtask

   task automatic t_polarity;
      logic [31:0] d;
      @(negedge clk); pin_in = 4'b0011;
      wr(3'd3, 32'h5, 4'hF);
      idle(5);
      rd(3'd4, d); check("R6 disarmed no flags", d, 32'h0);
      check("R8 no irq while disarmed", {31'h0, irq}, 32'h0);
      wr(3'd2, 32'hFFFF_FFFF, 4'hF);
      rd(3'd2, d); check("R3 enable upper zero", d, 32'hF);
      idle(3);
      rd(3'd4, d); check("R4 level match per polarity", d, 32'h9);
      check("R8 irq on pending", {31'h0, irq}, 32'h1);
   endtask

   task automatic t_w1c;
      logic [31:0] d;
      @(negedge clk); pin_in = 4'b1010;
      idle(5);
      rd(3'd4, d); check("R5 sticky after level gone", d, 32'h9);
      wr(3'd4, 32'h0, 4'hF);
      rd(3'd4, d); check("R5 write zero no effect", d, 32'h9);
      wr(3'd4, 32'h1, 4'hF);
      rd(3'd4, d); check("R5 clear bit0", d, 32'h8);
      check("R8 irq still set", {31'h0, irq}, 32'h1);
      wr(3'd4, 32'h8, 4'b1110);
      rd(3'd4, d); check("R9 clear gated by lane", d, 32'h8);
      wr(3'd4, 32'h8, 4'hF);
      rd(3'd4, d); check("R5 clear bit3", d, 32'h0);
      check("R8 irq drops", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_reassert;
      logic [31:0] d;
      @(negedge clk); pin_in = 4'b1000;
      idle(4);
      rd(3'd4, d); check("R4 low level on ch1", d, 32'h2);
      wr(3'd4, 32'h2, 4'hF);
      check("R7 cleared at write edge", {31'h0, irq}, 32'h0);
      @(negedge clk);
      check("R7 sets again next clock", {31'h0, irq}, 32'h1);
      rd(3'd4, d); check("R7 flag back", d, 32'h2);
   endtask

   task automatic t_disable;
      logic [31:0] d;
      wr(3'd2, 32'hD, 4'hF);
      wr(3'd4, 32'h2, 4'hF);
      idle(4);
      rd(3'd4, d); check("R6 disabled channel stays clear", d, 32'h0);
      check("R8 irq low", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_unmapped;
      logic [31:0] d;
      wr(3'd5, 32'hFFFF_FFFF, 4'hF);
      wr(3'd6, 32'hFFFF_FFFF, 4'hF);
      for (int a = 5; a < 8; a++) begin
         rd(3'(a), d);
         check($sformatf("R10 unmapped word %0d", a), d, 32'h0);
      end
      rd(3'd3, d); check("R10 polarity untouched", d, 32'h5);
      rd(3'd2, d); check("R10 enable untouched", d, 32'hD);
      @(negedge clk); reg_addr = 3'd1;
      idle(2);
      check("R10 rdata holds without read", reg_rdata, 32'hD);
   endtask

   task automatic t_rereset;
      logic [31:0] d;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(3'd2, d); check("R3 enable reset", d, 32'h0);
      rd(3'd1, d); check("R2 drive reset", d, 32'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_input();
      t_output();
      t_polarity();
      t_w1c();
      t_reassert();
      t_disable();
      t_unmapped();
      t_rereset();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule